// File: doc/BRIEF.md
# Control Endpoint Handshake Manager

This block sits between a USB packet engine and a microcontroller register interface and handles the device's bidirectional control endpoint (endpoint zero). The packet engine reports decoded events: a token (SETUP, OUT or IN), the data bytes of the packet that follows, and an end-of-packet strobe carrying the CRC result and the DATA0/DATA1 PID. The block picks the handshake (ACK, NAK, STALL or silence). It keeps the endpoint-zero configuration and status bits. It copies accepted packets into a setup buffer or an endpoint buffer through a one-byte-per-cycle write port.

Incoming bytes are held in a staging array until the packet is known to be good. Nothing visible changes for a corrupt, oversized or refused packet. A finite state machine has four states. ST_IDLE waits for a token. ST_RX_SETUP and ST_RX_OUT collect data bytes. ST_COMMIT copies an accepted packet to its buffer. The transitions are:
- IDLE→RX_SETUP on a SETUP token.
- IDLE→RX_OUT on an OUT token.
- IDLE→IDLE on an IN token, which is answered at once.
- RX_*→COMMIT on end-of-packet when the packet is accepted with a non-zero length.
- RX_*→IDLE on any other end-of-packet.
- COMMIT→IDLE after the last byte is written.

Firmware reads the configuration bits, the received byte count and the pending-setup flag on output ports. It changes them through a configuration write strobe and a write-one-to-clear interrupt strobe.

Top module: `ep0_handshake_mgr`

## Requirements
- R1: After reset, both configurations (bit 0 toggle, bit 1 nack, bit 2 stall, bit 3 interrupt enable, bit 4 endpoint enable) and the byte count are zero. The setup flag, both interrupts and `hs_valid` are low.
- R2: A handshake is a one-cycle `hs_valid` pulse with `hs_code` 1=ACK, 2=NAK, 3=STALL. For an IN token it comes in the cycle after the token. For a packet it comes in the cycle after `pkt_end`.
- R3: A SETUP packet with good CRC and exactly 8 bytes, on an enabled OUT configuration, is answered with ACK whatever the stall and nack bits are. Accepting it sets the setup flag, sets both toggle bits, clears both stall bits and writes the 8 bytes to the setup buffer (`wr_setup`=1). A SETUP packet of any other length gets no handshake and has no effect.
- R4: While the setup flag is set, every OUT or IN transaction is answered with NAK, whatever the stall and nack bits are.
- R5: With the setup flag clear, a transaction on a direction whose stall bit is set gets STALL. If the stall bit is clear and the nack bit is set, it gets NAK.
- R6: A good OUT packet with matching PID (DATA1 when toggle=1) and nack clear gets ACK. The bytes are written to the endpoint buffer (`wr_setup`=0) and the byte count is loaded. The toggle bit is inverted, nack is set and the endpoint interrupt becomes pending.
- R7: A good OUT packet whose PID differs from toggle, with nack clear, gets ACK. It is discarded: count, toggle, nack, pending interrupt and buffer stay unchanged.
- R8: A packet with a CRC error, or with more than MAX_BYTES data bytes, gets no handshake and changes no state or buffer.
- R9: Writing 1 to `clr_mask` bit 0 clears the setup interrupt and the setup flag. Writing 1 to bit 1 clears the endpoint interrupt.
- R10: `irq_setup` and `irq_ep` are levels. Each is its pending bit ANDed with the OUT interrupt-enable bit.
- R11: Any transaction addressed to a direction whose endpoint-enable bit is clear gets no handshake and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token type: 0 OUT, 1 IN, 2 SETUP |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| pkt_end | input | 1 | End-of-packet strobe |
| pkt_crc_ok | input | 1 | Packet CRC good, valid with pkt_end |
| pkt_data1 | input | 1 | Packet PID is DATA1, valid with pkt_end |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| wr_en | output | 1 | Buffer write strobe |
| wr_setup | output | 1 | 1 selects the setup buffer, 0 the endpoint buffer |
| wr_addr | output | 3 | Buffer byte address |
| wr_data | output | 8 | Buffer byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 OUT configuration, 1 IN configuration |
| cfg_wdata | input | 5 | New configuration value |
| clr_we | input | 1 | Interrupt clear strobe |
| clr_mask | input | 2 | Bit 0 setup interrupt, bit 1 endpoint interrupt, write one to clear |
| out_cfg | output | 5 | OUT configuration |
| in_cfg | output | 5 | IN configuration |
| out_count | output | 4 | Bytes in the last accepted OUT packet |
| setup_flag | output | 1 | Setup packet pending |
| irq_setup | output | 1 | Setup interrupt |
| irq_ep | output | 1 | Endpoint interrupt |

## Verification
The assertions assume that the packet engine never starts a token while a packet is being received or committed. They also assume that firmware register writes never land in the same cycle as an end-of-packet or IN token: a configuration write there would change the toggle without a handshake. The stimulus drives one transaction at a time from tasks. Each transaction is followed by a quiet gap longer than the widest commit. Register writes are issued only in the gaps before a transaction. The vector table carries each transaction's setup action, its expected handshake and the resulting toggle, nack, stall, setup flag and count.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX_SETUP,
        ST_RX_OUT,
        ST_COMMIT
    } st_e;

    typedef struct packed {
        logic en;
        logic ie;
        logic stall;
        logic nack;
        logic toggle;
    } ep_cfg_t;

    localparam int SETUP_BYTES = 8;

endpackage

// File: rtl/ep0_rx_stage.sv
module ep0_rx_stage #(
    parameter  int MAX_BYTES = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1),
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             byte_en,
    input  logic [7:0]       byte_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] nbytes,
    output logic             ovf
);

    logic [8*MAX_BYTES-1:0] flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbytes <= '0;
            ovf    <= 1'b0;
        end else if (start) begin
            nbytes <= '0;
            ovf    <= 1'b0;
        end else if (byte_en) begin
            if (nbytes == CNT_W'(MAX_BYTES)) ovf <= 1'b1;
            else                             nbytes <= nbytes + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     b_q <= '0;
            else if (byte_en && nbytes == CNT_W'(g))        b_q <= byte_in;
        end
        assign flat[g*8 +: 8] = b_q;
    end

    assign rd_data = flat[rd_idx*8 +: 8];

endmodule

// File: rtl/ep0_decide.sv
module ep0_decide
    import ep0_pkg::*;
#(
    parameter  int MAX_BYTES = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  tok_e             kind,
    input  logic             crc_ok,
    input  logic             ovf,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             pid1,
    input  logic             setup_flag,
    input  logic             out_en,
    input  logic             out_stall,
    input  logic             out_nack,
    input  logic             out_tog,
    input  logic             in_en,
    input  logic             in_stall,
    input  logic             in_nack,
    output hs_e              resp,
    output logic             take_setup,
    output logic             take_out
);

    always_comb begin
        resp       = HS_NONE;
        take_setup = 1'b0;
        take_out   = 1'b0;
        if (crc_ok && !ovf) begin
            unique case (kind)
                TK_SETUP: begin
                    if (out_en && nbytes == CNT_W'(SETUP_BYTES)) begin
                        resp       = HS_ACK;
                        take_setup = 1'b1;
                    end
                end
                TK_OUT: begin
                    if (out_en) begin
                        if (setup_flag)     resp = HS_NAK;
                        else if (out_stall) resp = HS_STALL;
                        else if (out_nack)  resp = HS_NAK;
                        else begin
                            resp     = HS_ACK;
                            take_out = (pid1 == out_tog);
                        end
                    end
                end
                TK_IN: begin
                    if (in_en) begin
                        if (setup_flag)    resp = HS_NAK;
                        else if (in_stall) resp = HS_STALL;
                        else if (in_nack)  resp = HS_NAK;
                        else               resp = HS_ACK;
                    end
                end
                default: resp = HS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ep0_regs.sv
module ep0_regs
    import ep0_pkg::*;
#(
    parameter  int MAX_BYTES = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  ep_cfg_t          cfg_wdata,
    input  logic             clr_we,
    input  logic [1:0]       clr_mask,
    input  logic             take_setup,
    input  logic             take_out,
    input  logic [CNT_W-1:0] out_len,
    output ep_cfg_t          out_q,
    output ep_cfg_t          in_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             setup_q,
    output logic             setup_pend_q,
    output logic             ep_pend_q
);

    ep_cfg_t          out_n, in_n;
    logic [CNT_W-1:0] cnt_n;
    logic             setup_n, setup_pend_n, ep_pend_n;

    always_comb begin
        out_n        = out_q;
        in_n         = in_q;
        cnt_n        = cnt_q;
        setup_n      = setup_q;
        setup_pend_n = setup_pend_q;
        ep_pend_n    = ep_pend_q;
        if (cfg_we) begin
            if (cfg_sel) in_n  = cfg_wdata;
            else         out_n = cfg_wdata;
        end
        if (clr_we) begin
            if (clr_mask[0]) begin
                setup_pend_n = 1'b0;
                setup_n      = 1'b0;
            end
            if (clr_mask[1]) ep_pend_n = 1'b0;
        end
        if (take_setup) begin
            setup_n      = 1'b1;
            setup_pend_n = 1'b1;
            out_n.stall  = 1'b0;
            in_n.stall   = 1'b0;
            out_n.toggle = 1'b1;
            in_n.toggle  = 1'b1;
        end
        if (take_out) begin
            cnt_n        = out_len;
            out_n.toggle = ~out_q.toggle;
            out_n.nack   = 1'b1;
            ep_pend_n    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q        <= '0;
            in_q         <= '0;
            cnt_q        <= '0;
            setup_q      <= 1'b0;
            setup_pend_q <= 1'b0;
            ep_pend_q    <= 1'b0;
        end else begin
            out_q        <= out_n;
            in_q         <= in_n;
            cnt_q        <= cnt_n;
            setup_q      <= setup_n;
            setup_pend_q <= setup_pend_n;
            ep_pend_q    <= ep_pend_n;
        end
    end

endmodule

// File: rtl/ep0_handshake_mgr.sv
module ep0_handshake_mgr
    import ep0_pkg::*;
#(
    parameter  int MAX_BYTES = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1),
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             pkt_end,
    input  logic             pkt_crc_ok,
    input  logic             pkt_data1,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             wr_en,
    output logic             wr_setup,
    output logic [IDX_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [4:0]       cfg_wdata,
    input  logic             clr_we,
    input  logic [1:0]       clr_mask,
    output logic [4:0]       out_cfg,
    output logic [4:0]       in_cfg,
    output logic [CNT_W-1:0] out_count,
    output logic             setup_flag,
    output logic             irq_setup,
    output logic             irq_ep
);

    st_e              state_q, state_n;
    logic [IDX_W-1:0] ptr_q, ptr_n;
    logic [CNT_W-1:0] len_q, len_n;
    logic             sel_q, sel_n;
    hs_e              hs_q, hs_n;

    tok_e             tok;
    logic             in_rx, eval_en, stage_start, stage_byte;
    tok_e             eval_kind;
    logic             eval_crc;
    logic [7:0]       stage_rd;
    logic [CNT_W-1:0] stage_cnt;
    logic             stage_ovf;
    hs_e              resp;
    logic             d_take_setup, d_take_out, take_setup, take_out;
    ep_cfg_t          out_q, in_q;
    logic             setup_pend, ep_pend;

    assign tok         = tok_e'(tok_kind);
    assign in_rx       = (state_q == ST_RX_SETUP) || (state_q == ST_RX_OUT);
    assign stage_start = (state_q == ST_IDLE) && tok_valid &&
                         (tok == TK_SETUP || tok == TK_OUT);
    assign stage_byte  = in_rx && rx_valid;
    assign eval_en     = ((state_q == ST_IDLE) && tok_valid && tok == TK_IN) ||
                         (in_rx && pkt_end);
    assign eval_kind   = (state_q == ST_RX_SETUP) ? TK_SETUP :
                         (state_q == ST_RX_OUT)   ? TK_OUT   : TK_IN;
    assign eval_crc    = in_rx ? pkt_crc_ok : 1'b1;
    assign take_setup  = eval_en && d_take_setup;
    assign take_out    = eval_en && d_take_out;

    ep0_rx_stage #(.MAX_BYTES(MAX_BYTES)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (stage_start),
        .byte_en (stage_byte),
        .byte_in (rx_data),
        .rd_idx  (ptr_q),
        .rd_data (stage_rd),
        .nbytes  (stage_cnt),
        .ovf     (stage_ovf)
    );

    ep0_decide #(.MAX_BYTES(MAX_BYTES)) u_decide (
        .kind       (eval_kind),
        .crc_ok     (eval_crc),
        .ovf        (stage_ovf && in_rx),
        .nbytes     (stage_cnt),
        .pid1       (pkt_data1),
        .setup_flag (setup_flag),
        .out_en     (out_q.en),
        .out_stall  (out_q.stall),
        .out_nack   (out_q.nack),
        .out_tog    (out_q.toggle),
        .in_en      (in_q.en),
        .in_stall   (in_q.stall),
        .in_nack    (in_q.nack),
        .resp       (resp),
        .take_setup (d_take_setup),
        .take_out   (d_take_out)
    );

    ep0_regs #(.MAX_BYTES(MAX_BYTES)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (ep_cfg_t'(cfg_wdata)),
        .clr_we       (clr_we),
        .clr_mask     (clr_mask),
        .take_setup   (take_setup),
        .take_out     (take_out),
        .out_len      (stage_cnt),
        .out_q        (out_q),
        .in_q         (in_q),
        .cnt_q        (out_count),
        .setup_q      (setup_flag),
        .setup_pend_q (setup_pend),
        .ep_pend_q    (ep_pend)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        len_n   = len_q;
        sel_n   = sel_q;
        hs_n    = eval_en ? resp : HS_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (stage_start) state_n = (tok == TK_SETUP) ? ST_RX_SETUP : ST_RX_OUT;
            end
            ST_RX_SETUP, ST_RX_OUT: begin
                if (pkt_end) begin
                    if ((take_setup || take_out) && stage_cnt != '0) begin
                        state_n = ST_COMMIT;
                        ptr_n   = '0;
                        len_n   = stage_cnt;
                        sel_n   = take_setup;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_COMMIT: begin
                ptr_n = ptr_q + IDX_W'(1);
                if ((CNT_W'(ptr_q) + CNT_W'(1)) == len_q) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            len_q   <= '0;
            sel_q   <= 1'b0;
            hs_q    <= HS_NONE;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
            len_q   <= len_n;
            sel_q   <= sel_n;
            hs_q    <= hs_n;
        end
    end

    // outputs
    always_comb begin
        hs_valid  = (hs_q != HS_NONE);
        hs_code   = hs_q;
        wr_en     = (state_q == ST_COMMIT);
        wr_setup  = sel_q;
        wr_addr   = ptr_q;
        wr_data   = stage_rd;
        out_cfg   = out_q;
        in_cfg    = in_q;
        irq_setup = setup_pend && out_q.ie;
        irq_ep    = ep_pend && out_q.ie;
    end

endmodule

// File: rtl/ep0_hs_checker.sv
module ep0_hs_checker #(
    parameter  int MAX_BYTES = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_valid,
    input logic [1:0]       hs_code,
    input logic             cfg_we,
    input logic [4:0]       out_cfg,
    input logic [CNT_W-1:0] out_count,
    input logic             setup_flag,
    input logic             irq_ep
);

    // R2: a handshake strobe always carries a real code
    a_r2_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code != 2'd0));

    // R4: no STALL while a setup was pending
    a_r4_setup_blocks_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd3) |-> !$past(setup_flag));

    // R3: the setup flag only rises together with an ACK
    a_r3_setup_rise_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_flag) |-> (hs_valid && hs_code == 2'd1));

    // R6, R7: the byte count only moves with an ACK
    a_r6_count_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count != $past(out_count)) |-> (hs_valid && hs_code == 2'd1));

    // R6: without a register write, the OUT toggle only moves with an ACK
    a_r6_toggle_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && out_cfg[0] != $past(out_cfg[0])) |-> (hs_valid && hs_code == 2'd1));

    // R10: endpoint interrupt needs the enable bit
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ep |-> out_cfg[3]);

endmodule

bind ep0_handshake_mgr ep0_hs_checker #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_valid   (hs_valid),
    .hs_code    (hs_code),
    .cfg_we     (cfg_we),
    .out_cfg    (out_cfg),
    .out_count  (out_count),
    .setup_flag (setup_flag),
    .irq_ep     (irq_ep)
);

// File: tb/sim_ep0_handshake_mgr.sv
`timescale 1ns/1ps
module sim_ep0_handshake_mgr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       pkt_end = 1'b0, pkt_crc_ok = 1'b0, pkt_data1 = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       wr_en, wr_setup;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [4:0] cfg_wdata = 5'd0;
    logic       clr_we = 1'b0;
    logic [1:0] clr_mask = 2'd0;
    logic [4:0] out_cfg, in_cfg;
    logic [3:0] out_count;
    logic       setup_flag, irq_setup, irq_ep;

    int checks = 0;
    int failures = 0;
    int n_writes = 0;
    logic [7:0] ep_mem [8];
    logic [7:0] su_mem [8];

    always #5 clk = ~clk;

    ep0_handshake_mgr u0 (.*);

    always @(negedge clk) begin
        if (wr_en) begin
            n_writes <= n_writes + 1;
            if (wr_setup) su_mem[wr_addr] <= wr_data;
            else          ep_mem[wr_addr] <= wr_data;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [4:0] val);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic clr_write(input logic [1:0] m);
        @(negedge clk); clr_we = 1'b1; clr_mask = m;
        @(negedge clk); clr_we = 1'b0;
    endtask

    // runs one transaction, returns the handshake code seen (0 = none)
    task automatic txn(input logic [1:0] kind, input int nb, input logic pid1,
                       input logic crc, input logic [3:0] tag, output int got);
        int seen;
        @(negedge clk); tok_valid = 1'b1; tok_kind = kind;
        @(negedge clk); tok_valid = 1'b0;
        if (kind == 2'd1) begin
            seen = hs_valid ? int'(hs_code) : 0;
        end else begin
            for (int b = 0; b < nb; b++) begin
                rx_valid = 1'b1; rx_data = {tag, 4'(b)};
                @(negedge clk);
            end
            rx_valid = 1'b0;
            pkt_end = 1'b1; pkt_crc_ok = crc; pkt_data1 = pid1;
            @(negedge clk);
            pkt_end = 1'b0;
            seen = hs_valid ? int'(hs_code) : 0;
        end
        repeat (12) @(negedge clk);
        got = seen;
    endtask

    // {kind2, nb4, pid1, crc1, pre2, hs2, tog1, nack1, stall1, setup1, cnt4}
    // pre: 0 none, 1 clear OUT nack, 2 clear setup interrupt, 3 set both stall bits
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 4'd3, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R6 accept
        {2'd0, 4'd3, 1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R5 nack
        {2'd0, 4'd2, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R6 DATA1
        {2'd0, 4'd2, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R7 mismatch
        {2'd0, 4'd4, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R8 crc
        {2'd2, 4'd8, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R3 setup
        {2'd0, 4'd2, 1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R4 out
        {2'd1, 4'd0, 1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R4 in
        {2'd2, 4'd8, 1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R3 over stall
        {2'd0, 4'd2, 1'b1, 1'b1, 2'd3, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2}, // R4 over stall
        {2'd1, 4'd0, 1'b0, 1'b1, 2'd2, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2}, // R5 in stall
        {2'd0, 4'd2, 1'b1, 1'b1, 2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2}, // R5 out stall
        {2'd2, 4'd8, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2}, // R8 setup crc
        {2'd2, 4'd8, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R3 setup
        {2'd0, 4'd5, 1'b1, 1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R9 then R6
        {2'd1, 4'd0, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R2 in ack
        {2'd2, 4'd6, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R3 short
        {2'd0, 4'd9, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}  // R8 oversize
    };

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int got;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hs_valid", int'(hs_valid), 0);
        check("R1 out_cfg", int'(out_cfg), 0);
        check("R1 in_cfg", int'(in_cfg), 0);
        check("R1 count", int'(out_count), 0);
        check("R1 setup_flag", int'(setup_flag), 0);
        check("R1 irqs", int'({irq_setup, irq_ep}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: disabled endpoints stay silent
        txn(2'd0, 2, 1'b0, 1'b1, 4'hF, got);
        check("R11 out disabled", got, 0);
        txn(2'd1, 0, 1'b0, 1'b1, 4'hF, got);
        check("R11 in disabled", got, 0);
        check("R11 count untouched", int'(out_count), 0);

        cfg_write(1'b0, 5'b11000);
        cfg_write(1'b1, 5'b11000);

        for (int v = 0; v < NV; v++) begin
            logic [19:0] e;
            e = VEC[v];
            unique case (e[11:10])
                2'd1: cfg_write(1'b0, out_cfg & 5'b11101);
                2'd2: clr_write(2'b01);
                2'd3: begin
                    cfg_write(1'b0, out_cfg | 5'b00100);
                    cfg_write(1'b1, in_cfg | 5'b00100);
                end
                default: ;
            endcase
            txn(e[19:18], int'(e[17:14]), e[13], e[12], 4'(v), got);
            check($sformatf("R2 R3 R4 R5 R6 R7 R8 hs vec%0d", v), got, int'(e[9:8]));
            check($sformatf("R6 R7 toggle vec%0d", v), int'(out_cfg[0]), int'(e[7]));
            check($sformatf("R6 R7 nack vec%0d", v), int'(out_cfg[1]), int'(e[6]));
            check($sformatf("R3 R5 stall vec%0d", v), int'(out_cfg[2]), int'(e[5]));
            check($sformatf("R3 R9 setup vec%0d", v), int'(setup_flag), int'(e[4]));
            check($sformatf("R6 R8 count vec%0d", v), int'(out_count), int'(e[3:0]));
        end

        // R3 setup buffer holds the last accepted setup (vec13)
        for (int k = 0; k < 8; k++)
            check($sformatf("R3 setup byte%0d", k), int'(su_mem[k]), int'({4'd13, 4'(k)}));
        // R6 endpoint buffer holds the last accepted OUT (vec14)
        for (int k = 0; k < 5; k++)
            check($sformatf("R6 ep byte%0d", k), int'(ep_mem[k]), int'({4'd14, 4'(k)}));
        // R7 R8: only accepted packets were written (3+2+8+8+8+5)
        check("R7 R8 write count", n_writes, 34);
        // R3 IN toggle set and stall cleared by the last setup
        check("R3 in toggle", int'(in_cfg[0]), 1);
        check("R3 in stall", int'(in_cfg[2]), 0);

        // R10 R9 interrupts
        check("R10 irq_ep pending", int'(irq_ep), 1);
        check("R9 irq_setup cleared", int'(irq_setup), 0);
        clr_write(2'b10);
        check("R9 irq_ep cleared", int'(irq_ep), 0);
        cfg_write(1'b0, 5'b10000);
        txn(2'd0, 2, 1'b0, 1'b1, 4'hA, got);
        check("R6 ack with ie off", got, 1);
        check("R10 gated low", int'(irq_ep), 0);
        cfg_write(1'b0, out_cfg | 5'b01000);
        check("R10 level high", int'(irq_ep), 1);
        txn(2'd2, 8, 1'b0, 1'b1, 4'hB, got);
        check("R10 irq_setup level", int'(irq_setup), 1);
        clr_write(2'b01);
        check("R9 setup flag cleared", int'(setup_flag), 0);
        check("R9 irq_setup low", int'(irq_setup), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule